// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block decides whether a selector may be loaded into a data segment register or into the stack segment register. A request presents the selector, the slot it targets, the current privilege level, the byte limit of the descriptor table and the 64-bit descriptor already fetched for that selector. Two clock edges later the block answers with either a commit or a protection fault. On a commit, the selector and descriptor are written into the block's shadow register file. On a fault, the file keeps its old contents and the fault vector and error code are reported.

The shadow file holds one selector/descriptor pair for each slot. Slot 0 is the stack segment register. Every other slot is a data segment register. A registered read port lets the surrounding pipeline, or a bench, see what each slot holds. All checks run in one stage, so a new request can be accepted on every cycle.

Top module: `seg_load_guard`

## Requirements
- R1: While reset is high and on the cycle after it, rsp_valid is 0. After reset every slot reads back selector 0 and descriptor 0.
- R2: A request sampled on a clock edge produces rsp_valid high for exactly one cycle, at the second following edge. Back-to-back requests produce back-to-back responses in order.
- R3: With index = selector bits 15:3, the load faults with vector 13 when index*8+7 exceeds the table limit. index*8+7 equal to the limit passes.
- R4: A data slot load faults with vector 13 when descriptor bit 44 (code/data flag) is 0. It also faults when bit 43 (executable) is 1 and bit 41 (readable) is 0. A readable code segment or any data segment, including a read-only one, is accepted.
- R5: A data slot load faults with vector 13 when max(current level, selector bits 1:0) is numerically greater than descriptor bits 46:45. Level 0 is the most privileged.
- R6: A stack slot load faults with vector 13 unless bit 44 is 1, bit 43 is 0 and bit 41 (writable) is 1.
- R7: A stack slot load faults with vector 13 unless descriptor bits 46:45 and selector bits 1:0 both equal the current level.
- R8: When every other check passes but descriptor bit 47 (present) is 0, the fault vector is 11 for a data slot and 12 for a stack slot. The limit, type and privilege faults (vector 13) take priority over it.
- R9: On a fault, rsp_fault is 1, rsp_errcode equals the request's selector, and the target slot keeps its previous selector and descriptor.
- R10: On a commit, rsp_fault, rsp_vector and rsp_errcode are 0. Reading the target slot from the next cycle onward returns the request's selector and descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_slot | input | $clog2(NUM_SLOTS) | Target slot; 0 is the stack register |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_limit | input | LIMIT_W | Descriptor table byte limit |
| req_desc | input | 64 | Descriptor fetched for the selector |
| rd_slot | input | $clog2(NUM_SLOTS) | Shadow file read address |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Load rejected |
| rsp_vector | output | 8 | Fault vector (11, 12 or 13), 0 on commit |
| rsp_errcode | output | 16 | Selector of the faulting load, 0 on commit |
| rd_sel | output | 16 | Selector held in the addressed slot |
| rd_desc | output | 64 | Descriptor held in the addressed slot |

## Verification
Inputs are driven on the falling edge. A request driven there is captured on the next rising edge, and its response registers load on the rising edge after that. The bench therefore samples the response two falling edges after it drives the request, and it also checks that rsp_valid is low one falling edge before that point and again one falling edge after it. The shadow file is written on the response edge and its read port adds one register. For that reason, slot contents are checked one falling edge after the response, with rd_slot set at the response sample point.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int VEC_W  = 8;

  localparam logic [VEC_W-1:0] VEC_GENERAL  = 8'd13;
  localparam logic [VEC_W-1:0] VEC_ABSENT   = 8'd11;
  localparam logic [VEC_W-1:0] VEC_STACKF   = 8'd12;

  // descriptor bit positions the checks depend on
  localparam int DB_PRESENT = 47;
  localparam int DB_DPL_HI  = 46;
  localparam int DB_DPL_LO  = 45;
  localparam int DB_CODEDAT = 44;
  localparam int DB_EXEC    = 43;
  localparam int DB_RDWR    = 41;

  typedef struct packed {
    logic [SEL_W-4:0] index;
    logic             tbl;
    logic [1:0]       rpl;
  } selector_t;

  typedef struct packed {
    logic limit_bad;
    logic type_bad;
    logic priv_bad;
    logic absent;
  } check_flags_t;

  function automatic logic [1:0] weaker_level(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seg_type_check.sv
module seg_type_check
  import seg_guard_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic              is_stack,
  input  selector_t         sel,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [DESC_W-1:0] desc,
  output logic              limit_bad,
  output logic              type_bad,
  output logic              absent
);

  localparam int IDX_W = SEL_W - 3;
  localparam int CMP_W = ((LIMIT_W > SEL_W) ? LIMIT_W : SEL_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] limit_ext;
  logic             code_data;
  logic             exec;
  logic             rdwr;

  always_comb begin
    last_byte = CMP_W'({sel.index, 3'b111});
    limit_ext = CMP_W'(limit);
    limit_bad = last_byte > limit_ext;
  end

  always_comb begin
    code_data = desc[DB_CODEDAT];
    exec      = desc[DB_EXEC];
    rdwr      = desc[DB_RDWR];
    if (is_stack) begin
      // stack: writable data segment only
      type_bad = !code_data || exec || !rdwr;
    end else begin
      // data register: anything but system descriptors and execute-only code
      type_bad = !code_data || (exec && !rdwr);
    end
    absent = !desc[DB_PRESENT];
  end

  logic unused_tbl;
  assign unused_tbl = sel.tbl ^ (|sel.rpl) ^ (|IDX_W);

endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
  import seg_guard_pkg::*;
(
  input  logic       is_stack,
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  input  logic [1:0] dpl,
  output logic [1:0] eff_level,
  output logic       priv_bad
);

  always_comb begin
    eff_level = weaker_level(cpl, rpl);
    if (is_stack) begin
      priv_bad = (dpl != cpl) || (rpl != cpl);
    end else begin
      priv_bad = eff_level > dpl;
    end
  end

endmodule

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
  import seg_guard_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_slot,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DESC_W-1:0]            wr_desc,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
  output logic [SEL_W-1:0]             rd_sel,
  output logic [DESC_W-1:0]            rd_desc
);

  localparam int ENTRY_W = SEL_W + DESC_W;

  logic [ENTRY_W-1:0]   mem [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] loaded;
  logic [ENTRY_W-1:0]   rd_word;

  // data array without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= {wr_sel, wr_desc};
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_loaded
      always_ff @(posedge clk) begin
        if (rst) loaded[g] <= 1'b0;
        else if (wr_en && (wr_slot == g)) loaded[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else     rd_word <= loaded[rd_slot] ? mem[rd_slot] : '0;
  end

  assign rd_sel  = rd_word[ENTRY_W-1 -: SEL_W];
  assign rd_desc = rd_word[DESC_W-1:0];

  // R10: a committed entry is what the read port returns once addressed
  a_r10_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en ##1 (rd_slot == $past(wr_slot))) |=> (rd_sel == $past(wr_sel, 2)))
    else $error("a_r10_write_visible");

endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
  import seg_guard_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int STACK_SLOT = 0,
  parameter int LIMIT_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [$clog2(NUM_SLOTS)-1:0] req_slot,
  input  logic [15:0]                  req_sel,
  input  logic [1:0]                   req_cpl,
  input  logic [LIMIT_W-1:0]           req_limit,
  input  logic [63:0]                  req_desc,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
  output logic                         rsp_valid,
  output logic                         rsp_fault,
  output logic [7:0]                   rsp_vector,
  output logic [15:0]                  rsp_errcode,
  output logic [15:0]                  rd_sel,
  output logic [63:0]                  rd_desc
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  // stage 1: captured request
  logic                s1_valid;
  logic [SLOT_W-1:0]   s1_slot;
  selector_t           s1_sel;
  logic [1:0]          s1_cpl;
  logic [LIMIT_W-1:0]  s1_limit;
  logic [DESC_W-1:0]   s1_desc;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_slot  <= '0;
      s1_sel   <= '0;
      s1_cpl   <= '0;
      s1_limit <= '0;
      s1_desc  <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_slot  <= req_slot;
        s1_sel   <= selector_t'(req_sel);
        s1_cpl   <= req_cpl;
        s1_limit <= req_limit;
        s1_desc  <= req_desc;
      end
    end
  end

  logic         s1_stack;
  logic [1:0]   s1_dpl;
  logic [1:0]   s1_eff;
  check_flags_t flags;

  assign s1_stack = (s1_slot == SLOT_W'(STACK_SLOT));
  assign s1_dpl   = s1_desc[DB_DPL_HI:DB_DPL_LO];

  seg_type_check #(.LIMIT_W(LIMIT_W)) u_type (
    .is_stack  (s1_stack),
    .sel       (s1_sel),
    .limit     (s1_limit),
    .desc      (s1_desc),
    .limit_bad (flags.limit_bad),
    .type_bad  (flags.type_bad),
    .absent    (flags.absent)
  );

  seg_priv_check u_priv (
    .is_stack  (s1_stack),
    .cpl       (s1_cpl),
    .rpl       (s1_sel.rpl),
    .dpl       (s1_dpl),
    .eff_level (s1_eff),
    .priv_bad  (flags.priv_bad)
  );

  // fault merge: vector 13 causes outrank the presence check
  logic             general_bad;
  logic             any_bad;
  logic [VEC_W-1:0] vec_next;

  always_comb begin
    general_bad = flags.limit_bad || flags.type_bad || flags.priv_bad;
    any_bad     = general_bad || flags.absent;
    if (general_bad)       vec_next = VEC_GENERAL;
    else if (flags.absent) vec_next = s1_stack ? VEC_STACKF : VEC_ABSENT;
    else                   vec_next = '0;
  end

  logic commit;
  assign commit = s1_valid && !any_bad;

  // stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_vector  <= '0;
      rsp_errcode <= '0;
    end else begin
      rsp_valid   <= s1_valid;
      rsp_fault   <= s1_valid && any_bad;
      rsp_vector  <= s1_valid ? vec_next : '0;
      rsp_errcode <= (s1_valid && any_bad) ? SEL_W'(s1_sel) : '0;
    end
  end

  seg_shadow_file #(.NUM_SLOTS(NUM_SLOTS)) u_file (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (commit),
    .wr_slot (s1_slot),
    .wr_sel  (SEL_W'(s1_sel)),
    .wr_desc (s1_desc),
    .rd_slot (rd_slot),
    .rd_sel  (rd_sel),
    .rd_desc (rd_desc)
  );

  // R1: no response on the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid)
    else $error("a_r1_quiet_after_reset");

  // R2: response follows request by two edges
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_valid)
    else $error("a_r2_latency");

  // R5: committed data loads satisfy the effective privilege rule
  a_r5_data_priv: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && !$past(s1_stack)) |-> ($past(s1_eff) <= $past(s1_dpl)))
    else $error("a_r5_data_priv");

  // R7: committed stack loads run at exactly the current level
  a_r7_stack_level: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && $past(s1_stack)) |->
      (($past(s1_dpl) == $past(s1_cpl)) && ($past(s1_sel.rpl) == $past(s1_cpl))))
    else $error("a_r7_stack_level");

  // R8: only the three defined vectors appear on a fault
  a_r8_vector_set: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |->
      (rsp_vector == 8'd13 || rsp_vector == 8'd11 || rsp_vector == 8'd12))
    else $error("a_r8_vector_set");

  // R9: a fault carries the captured selector
  a_r9_errcode: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_errcode == 16'($past(s1_sel))))
    else $error("a_r9_errcode");

  // R10: a commit reports clean fields
  a_r10_clean_commit: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_vector == '0 && rsp_errcode == '0))
    else $error("a_r10_clean_commit");

endmodule

// File: tb/tb_seg_load_guard.sv
`timescale 1ns/1ps
module tb_seg_load_guard;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_slot;
  logic [15:0] req_sel;
  logic [1:0]  req_cpl;
  logic [15:0] req_limit;
  logic [63:0] req_desc;
  logic [1:0]  rd_slot;
  logic        rsp_valid, rsp_fault;
  logic [7:0]  rsp_vector;
  logic [15:0] rsp_errcode, rd_sel;
  logic [63:0] rd_desc;

  always #2.5 clk = ~clk;

  seg_load_guard dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_slot(req_slot),
    .req_sel(req_sel), .req_cpl(req_cpl), .req_limit(req_limit),
    .req_desc(req_desc), .rd_slot(rd_slot), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_vector(rsp_vector), .rsp_errcode(rsp_errcode),
    .rd_sel(rd_sel), .rd_desc(rd_desc)
  );

  typedef struct packed {
    logic [1:0]  slot;
    logic [15:0] sel;
    logic [1:0]  cpl;
    logic [15:0] lim;
    logic        p;
    logic [1:0]  dpl;
    logic        s;
    logic [3:0]  typ;
    logic        ef;
    logic [7:0]  ev;
    logic [7:0]  req;
  } vec_t;

  // types: 2 = data RW, 0 = data RO, 8 = exec-only code, A = readable code
  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 16'h0010, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b1, 4'h2, 1'b0, 8'd0,  8'd4},  // R4 data RW
    '{2'd2, 16'h0018, 2'd3, 16'hFFFF, 1'b1, 2'd3, 1'b1, 4'h0, 1'b0, 8'd0,  8'd4},  // R4 read-only ok
    '{2'd3, 16'h0020, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b1, 4'hA, 1'b0, 8'd0,  8'd4},  // R4 readable code
    '{2'd1, 16'h0028, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b1, 4'h8, 1'b1, 8'd13, 8'd4},  // R4 exec-only
    '{2'd1, 16'h0030, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b0, 4'h2, 1'b1, 8'd13, 8'd4},  // R4 system desc
    '{2'd2, 16'h0013, 2'd0, 16'hFFFF, 1'b1, 2'd2, 1'b1, 4'h2, 1'b1, 8'd13, 8'd5},  // R5 rpl weakens
    '{2'd2, 16'h0010, 2'd2, 16'hFFFF, 1'b1, 2'd1, 1'b1, 4'h2, 1'b1, 8'd13, 8'd5},  // R5 cpl too weak
    '{2'd2, 16'h0011, 2'd1, 16'hFFFF, 1'b1, 2'd1, 1'b1, 4'h2, 1'b0, 8'd0,  8'd5},  // R5 equal ok
    '{2'd3, 16'h0010, 2'd0, 16'h0017, 1'b1, 2'd0, 1'b1, 4'h2, 1'b0, 8'd0,  8'd3},  // R3 exact fit
    '{2'd3, 16'h0040, 2'd0, 16'h0016, 1'b1, 2'd0, 1'b1, 4'h2, 1'b1, 8'd13, 8'd3},  // R3 over limit
    '{2'd1, 16'h0048, 2'd0, 16'hFFFF, 1'b0, 2'd0, 1'b1, 4'h2, 1'b1, 8'd11, 8'd8},  // R8 data absent
    '{2'd0, 16'h0012, 2'd2, 16'hFFFF, 1'b1, 2'd2, 1'b1, 4'h2, 1'b0, 8'd0,  8'd7},  // R7 stack ok
    '{2'd0, 16'h0050, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b1, 4'h0, 1'b1, 8'd13, 8'd6},  // R6 stack RO
    '{2'd0, 16'h0058, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b1, 4'hA, 1'b1, 8'd13, 8'd6},  // R6 stack code
    '{2'd0, 16'h0060, 2'd0, 16'hFFFF, 1'b1, 2'd1, 1'b1, 4'h2, 1'b1, 8'd13, 8'd7},  // R7 dpl mismatch
    '{2'd0, 16'h0061, 2'd0, 16'hFFFF, 1'b1, 2'd0, 1'b1, 4'h2, 1'b1, 8'd13, 8'd7},  // R7 rpl mismatch
    '{2'd0, 16'h0068, 2'd0, 16'hFFFF, 1'b0, 2'd0, 1'b1, 4'h2, 1'b1, 8'd12, 8'd8},  // R8 stack absent
    '{2'd3, 16'h0070, 2'd0, 16'h0016, 1'b0, 2'd0, 1'b1, 4'h2, 1'b1, 8'd13, 8'd8},  // R8 limit wins
    '{2'd0, 16'h0078, 2'd1, 16'hFFFF, 1'b0, 2'd0, 1'b1, 4'h2, 1'b1, 8'd13, 8'd8}   // R8 priv wins
  };

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_sel  [4];
  logic [63:0] m_desc [4];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic p, input logic [1:0] dpl, input logic s, input logic [3:0] typ);
    return 64'h00CF_0000_0000_FFFF | {16'h0, p, dpl, s, typ, 40'h0};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_desc[i] = '0; end
  endtask

  // drive at negedge; result due after two rising edges
  task automatic issue(input logic [1:0] slot, input logic [15:0] sel, input logic [1:0] cpl,
                       input logic [15:0] lim, input logic [63:0] desc);
    req_slot = slot; req_sel = sel; req_cpl = cpl; req_limit = lim; req_desc = desc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", {63'd0, rsp_valid}, 64'd0, "early rsp_valid");
    @(negedge clk);
  endtask

  task automatic check_slot(input logic [1:0] slot, input string req);
    rd_slot = slot;
    @(negedge clk);
    check(req, {48'd0, rd_sel}, {48'd0, m_sel[slot]}, "slot selector");
    check(req, rd_desc, m_desc[slot], "slot descriptor");
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_slot = '0; req_sel = '0; req_cpl = '0;
    req_limit = '0; req_desc = '0; rd_slot = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", {63'd0, rsp_valid}, 64'd0, "rsp_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", {63'd0, rsp_valid}, 64'd0, "rsp_valid after reset");
    for (int i = 0; i < 4; i++) check_slot(2'(i), "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [63:0] d;
      string rq;
      d  = mk_desc(TBL[i].p, TBL[i].dpl, TBL[i].s, TBL[i].typ);
      rq = $sformatf("R%0d", TBL[i].req);
      issue(TBL[i].slot, TBL[i].sel, TBL[i].cpl, TBL[i].lim, d);
      check("R2", {63'd0, rsp_valid}, 64'd1, "rsp_valid");
      check(rq, {63'd0, rsp_fault}, {63'd0, TBL[i].ef}, $sformatf("fault v%0d", i));
      check(rq, {56'd0, rsp_vector}, {56'd0, TBL[i].ev}, $sformatf("vector v%0d", i));
      check(TBL[i].ef ? "R9" : "R10", {48'd0, rsp_errcode},
            {48'd0, TBL[i].ef ? TBL[i].sel : 16'h0}, $sformatf("errcode v%0d", i));
      if (!TBL[i].ef) begin
        m_sel[TBL[i].slot]  = TBL[i].sel;
        m_desc[TBL[i].slot] = d;
      end
      check_slot(TBL[i].slot, TBL[i].ef ? "R9" : "R10");
      check("R2", {63'd0, rsp_valid}, 64'd0, "single-cycle rsp_valid");
    end

    // R2: back-to-back requests answered in order
    req_slot = 2'd1; req_sel = 16'h0080; req_cpl = 2'd0; req_limit = 16'hFFFF;
    req_desc = mk_desc(1'b1, 2'd0, 1'b1, 4'h2); req_valid = 1'b1;
    @(negedge clk);
    req_sel = 16'h0083; req_desc = mk_desc(1'b1, 2'd1, 1'b1, 4'h2);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", {63'd0, rsp_valid}, 64'd1, "first of pair valid");
    check("R2", {63'd0, rsp_fault}, 64'd0, "first of pair commit");
    @(negedge clk);
    check("R2", {63'd0, rsp_valid}, 64'd1, "second of pair valid");
    check("R5", {56'd0, rsp_vector}, 64'd13, "second of pair vector");
    check("R9", {48'd0, rsp_errcode}, 64'h0083, "second of pair errcode");
    m_sel[1] = 16'h0080; m_desc[1] = mk_desc(1'b1, 2'd0, 1'b1, 4'h2);
    check_slot(2'd1, "R9");

    // R1: mid-run reset clears the shadow file
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1", {63'd0, rsp_valid}, 64'd0, "rsp_valid after second reset");
    for (int i = 0; i < 4; i++) check_slot(2'(i), "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule